// File: doc/BRIEF.md
# Machine-Check Outcome and Debug-Entry Controller

This block decides what a processor core does when a machine-check event arrives. Three outcomes are possible: a sticky check-stop halt, a one-cycle request to branch to the machine-check handler, or entry into debug mode. The choice depends on four configuration inputs. These are the core's machine-check enable, a global debug enable, a per-case "stop goes to debug" bit and a per-case "machine-check interrupt goes to debug" bit.

Each event that is accepted loads a 32-bit cause register with a one-hot code. Bit 29 set means the event arrived with machine checks disabled. Bit 28 set means it arrived with machine checks enabled. The debug port reads this register through a read strobe, and the read clears the register. In debug mode the block raises a freeze output so that peripherals can halt, and it drives a two-bit status output to binary 11. Software can also raise freeze directly. Debug mode is left only by an exit strobe from the debug port. Check-stop is left only by reset.

Top module: `mc_debug_ctrl`

## Requirements
- R1: When debug is disabled and machine-check enable is 0, an event enters check-stop (`chkstop`=1) and loads the cause register with 0x2000_0000 (bit 29).
- R2: When debug is disabled and machine-check enable is 1, an event raises `branch_req` for exactly one cycle, stays out of check-stop and debug, and loads the cause register with 0x1000_0000 (bit 28).
- R3: When debug is enabled and machine-check enable is 0, the stop-to-debug bit selects the outcome: 0 selects check-stop and 1 selects debug mode. The cause is 0x2000_0000 in both cases.
- R4: When debug is enabled and machine-check enable is 1, the interrupt-to-debug bit selects the outcome: 0 selects the handler branch and 1 selects debug mode. The cause is 0x1000_0000 in both cases.
- R5: In debug mode `freeze` is 1 and `status_pins` is 2'b11. Outside debug mode `status_pins` is 2'b00.
- R6: `cause_value` shows the register contents during a read cycle. A read with no event in the same cycle clears all 32 bits at the next edge.
- R7: When a read and an accepted event fall in the same cycle, the newly captured cause is kept.
- R8: `sw_freeze` drives `freeze` high in any mode and leaves `status_pins` unchanged.
- R9: Check-stop holds until reset. While it holds, events and exit strobes have no effect: no branch, no status change and no cause capture.
- R10: Debug mode is left only by `dbg_exit`, which returns the core to normal running. Events that arrive during debug mode have no effect.
- R11: After reset, `freeze`, `status_pins`, `chkstop`, `branch_req` and `cause_value` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_en | input | 1 | Core machine-check enable |
| dbg_en | input | 1 | Debug mode enable |
| stop_to_dbg | input | 1 | Send the check-stop case to debug mode |
| mci_to_dbg | input | 1 | Send the handler-branch case to debug mode |
| mc_event | input | 1 | Machine-check event strobe |
| cause_rd | input | 1 | Debug-port read strobe for the cause register |
| dbg_exit | input | 1 | Debug-port strobe that leaves debug mode |
| sw_freeze | input | 1 | Software freeze request |
| freeze | output | 1 | Peripheral freeze |
| status_pins | output | 2 | Core status, 2'b11 in debug mode |
| chkstop | output | 1 | Check-stop state indicator |
| branch_req | output | 1 | One-cycle request to branch to the handler |
| cause_value | output | 32 | Exception cause register contents |

## Verification
The bench covers eight combinations of the configuration bits, including cases where a "don't care" bit is set the opposite way. A decoder that looked at the wrong per-case bit would therefore pick the wrong outcome or the wrong cause code. The bench issues a read in the same cycle as a capture, which exposes a design that lets the clear win. It also applies exit strobes and events during check-stop and during debug mode, which catches a design that leaves check-stop, recaptures the cause, or drops out of debug without an exit strobe. A branch request that lasted longer than one cycle is seen on the cycle after the pulse.

// File: rtl/mcdc_pkg.sv
package mcdc_pkg;

  typedef enum logic [1:0] {
    OUT_BRANCH  = 2'd0,
    OUT_CHKSTOP = 2'd1,
    OUT_DEBUG   = 2'd2
  } mc_outcome_e;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_CHKSTOP = 2'd1,
    MODE_DEBUG   = 2'd2
  } core_mode_e;

  // Outcome decision: the debug enable gates both per-case bits.
  function automatic mc_outcome_e pick_outcome(input logic me, input logic dbg,
                                               input logic s2d, input logic m2d);
    if (!dbg)
      return me ? OUT_BRANCH : OUT_CHKSTOP;
    if (me)
      return m2d ? OUT_DEBUG : OUT_BRANCH;
    return s2d ? OUT_DEBUG : OUT_CHKSTOP;
  endfunction

  // Status pin code for a given mode.
  function automatic logic [1:0] status_code(input core_mode_e m);
    return (m == MODE_DEBUG) ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/mcdc_decide.sv
module mcdc_decide
  import mcdc_pkg::*;
(
  input  logic        me,
  input  logic        dbg,
  input  logic        s2d,
  input  logic        m2d,
  output mc_outcome_e outcome
);
  always_comb outcome = pick_outcome(me, dbg, s2d, m2d);
endmodule

// File: rtl/mcdc_cause_reg.sv
module mcdc_cause_reg #(
  parameter int W       = 32,
  parameter int MC_BIT  = 28,
  parameter int CHK_BIT = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_me,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MC_CODE  = W'(1) << MC_BIT;
  localparam logic [W-1:0] CHK_CODE = W'(1) << CHK_BIT;

  // A capture takes priority over the clear that a read causes.
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (load)
      q <= load_me ? MC_CODE : CHK_CODE;
    else if (clr)
      q <= '0;
  end
endmodule

// File: rtl/mcdc_mode_fsm.sv
module mcdc_mode_fsm
  import mcdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mc_event,
  input  mc_outcome_e outcome,
  input  logic        dbg_exit,
  output core_mode_e  mode,
  output logic        accept,
  output logic        branch_pulse
);
  // Events count only while the core runs normally.
  assign accept = mc_event && (mode == MODE_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode         <= MODE_RUN;
      branch_pulse <= 1'b0;
    end else begin
      branch_pulse <= accept && (outcome == OUT_BRANCH);
      case (mode)
        MODE_RUN: begin
          if (accept && outcome == OUT_CHKSTOP) mode <= MODE_CHKSTOP;
          else if (accept && outcome == OUT_DEBUG) mode <= MODE_DEBUG;
        end
        MODE_DEBUG: if (dbg_exit) mode <= MODE_RUN;
        MODE_CHKSTOP: mode <= MODE_CHKSTOP;
        default: mode <= MODE_RUN;
      endcase
    end
  end
endmodule

// File: rtl/mc_debug_ctrl.sv
module mc_debug_ctrl
  import mcdc_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int MC_BIT  = 28,
  parameter int CHK_BIT = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mc_en,
  input  logic               dbg_en,
  input  logic               stop_to_dbg,
  input  logic               mci_to_dbg,
  input  logic               mc_event,
  input  logic               cause_rd,
  input  logic               dbg_exit,
  input  logic               sw_freeze,
  output logic               freeze,
  output logic [1:0]         status_pins,
  output logic               chkstop,
  output logic               branch_req,
  output logic [CAUSE_W-1:0] cause_value
);
  mc_outcome_e outcome;
  core_mode_e  mode;
  logic        mc_accept;

  mcdc_decide u_decide (
    .me(mc_en), .dbg(dbg_en), .s2d(stop_to_dbg), .m2d(mci_to_dbg),
    .outcome(outcome)
  );

  mcdc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mc_event(mc_event), .outcome(outcome),
    .dbg_exit(dbg_exit), .mode(mode), .accept(mc_accept),
    .branch_pulse(branch_req)
  );

  mcdc_cause_reg #(.W(CAUSE_W), .MC_BIT(MC_BIT), .CHK_BIT(CHK_BIT)) u_cause (
    .clk(clk), .rst_n(rst_n), .load(mc_accept), .load_me(mc_en),
    .clr(cause_rd), .q(cause_value)
  );

  assign freeze      = sw_freeze || (mode == MODE_DEBUG);
  assign status_pins = status_code(mode);
  assign chkstop     = (mode == MODE_CHKSTOP);
endmodule

// File: rtl/mcdc_checker.sv
module mcdc_checker #(
  parameter int W       = 32,
  parameter int MC_BIT  = 28,
  parameter int CHK_BIT = 29
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mc_en,
  input logic         cause_rd,
  input logic         dbg_exit,
  input logic         sw_freeze,
  input logic         mc_accept,
  input logic         freeze,
  input logic [1:0]   status_pins,
  input logic         chkstop,
  input logic         branch_req,
  input logic [W-1:0] cause_value
);
  localparam logic [W-1:0] MC_CODE  = W'(1) << MC_BIT;
  localparam logic [W-1:0] CHK_CODE = W'(1) << CHK_BIT;

  p_chk_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_accept && !mc_en) |=> (cause_value == CHK_CODE));

  p_mc_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_accept && mc_en) |=> (cause_value == MC_CODE));

  p_branch_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    branch_req |-> $past(mc_accept && mc_en));

  p_debug_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_pins == 2'b11) |-> freeze);

  p_status_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_pins != 2'b11) |-> (status_pins == 2'b00));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && !mc_accept) |=> (cause_value == '0));

  p_sw_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_freeze |-> freeze);

  p_chk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chkstop |=> chkstop);

  p_debug_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_pins == 2'b11 && !dbg_exit) |=> (status_pins == 2'b11));
endmodule

bind mc_debug_ctrl mcdc_checker #(.W(CAUSE_W), .MC_BIT(MC_BIT), .CHK_BIT(CHK_BIT)) i_mcdc_chk (
  .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cause_rd(cause_rd),
  .dbg_exit(dbg_exit), .sw_freeze(sw_freeze), .mc_accept(mc_accept),
  .freeze(freeze), .status_pins(status_pins), .chkstop(chkstop),
  .branch_req(branch_req), .cause_value(cause_value)
);

// File: tb/test_mc_debug_ctrl.sv
module test_mc_debug_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, mc_en, dbg_en, stop_to_dbg, mci_to_dbg;
  logic        mc_event, cause_rd, dbg_exit, sw_freeze;
  logic        freeze, chkstop, branch_req;
  logic [1:0]  status_pins;
  logic [31:0] cause_value;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [31:0] C_MC  = 32'h1000_0000;
  localparam logic [31:0] C_CHK = 32'h2000_0000;

  // Row: {mc_en, dbg_en, stop_to_dbg, mci_to_dbg, outcome}; outcome 0 branch, 1 stop, 2 debug
  localparam logic [5:0] VEC [8] = '{
    6'b0011_01, 6'b1011_00, 6'b0101_01, 6'b0110_10,
    6'b1110_00, 6'b1101_10, 6'b0000_01, 6'b1000_00
  };

  always #2 clk = ~clk;

  mc_debug_ctrl i_mc_debug_ctrl (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .dbg_en(dbg_en),
    .stop_to_dbg(stop_to_dbg), .mci_to_dbg(mci_to_dbg), .mc_event(mc_event),
    .cause_rd(cause_rd), .dbg_exit(dbg_exit), .sw_freeze(sw_freeze),
    .freeze(freeze), .status_pins(status_pins), .chkstop(chkstop),
    .branch_req(branch_req), .cause_value(cause_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mc_event = 1'b0; cause_rd = 1'b0; dbg_exit = 1'b0; sw_freeze = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {mc_en, dbg_en, stop_to_dbg, mci_to_dbg} = c;
  endtask

  // Pulse strobes for one cycle starting at a negedge; returns at the next negedge.
  task automatic pulse(input logic ev, input logic rd, input logic ex);
    mc_event = ev; cause_rd = rd; dbg_exit = ex;
    @(negedge clk);
    mc_event = 1'b0; cause_rd = 1'b0; dbg_exit = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; set_cfg(4'b0000);
    do_reset();

    // R11 reset state
    check("R11 freeze", {31'd0, freeze}, 32'd0);
    check("R11 status", {30'd0, status_pins}, 32'd0);
    check("R11 chkstop", {31'd0, chkstop}, 32'd0);
    check("R11 branch", {31'd0, branch_req}, 32'd0);
    check("R11 cause", cause_value, 32'd0);

    // R1..R4 outcome table, R5 pins, R2 pulse width
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  oc;
      logic [31:0] ec;
      do_reset();
      set_cfg(VEC[i][5:2]);
      oc = VEC[i][1:0];
      ec = VEC[i][5] ? C_MC : C_CHK;
      @(negedge clk);
      pulse(1'b1, 1'b0, 1'b0);
      check($sformatf("R1_R2_R3_R4 row%0d cause", i), cause_value, ec);
      check($sformatf("R1_R3 row%0d chkstop", i), {31'd0, chkstop}, {31'd0, oc == 2'd1});
      check($sformatf("R2_R4 row%0d branch", i), {31'd0, branch_req}, {31'd0, oc == 2'd0});
      check($sformatf("R5 row%0d status", i), {30'd0, status_pins}, (oc == 2'd2) ? 32'd3 : 32'd0);
      check($sformatf("R5 row%0d freeze", i), {31'd0, freeze}, {31'd0, oc == 2'd2});
      @(negedge clk);
      check($sformatf("R2 row%0d pulse ends", i), {31'd0, branch_req}, 32'd0);
    end

    // R6: value visible during read, cleared afterwards
    do_reset(); set_cfg(4'b1000);
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cause_rd = 1'b1;
    #0;
    check("R6 value during read", cause_value, C_MC);
    @(negedge clk); cause_rd = 1'b0;
    check("R6 cleared", cause_value, 32'd0);

    // R7: read and capture in the same cycle
    pulse(1'b1, 1'b1, 1'b0);
    check("R7 capture wins", cause_value, C_MC);

    // R8: software freeze without debug mode
    sw_freeze = 1'b1;
    @(negedge clk);
    check("R8 freeze", {31'd0, freeze}, 32'd1);
    check("R8 status", {30'd0, status_pins}, 32'd0);
    sw_freeze = 1'b0;
    @(negedge clk);
    check("R8 release", {31'd0, freeze}, 32'd0);

    // R9: check-stop sticky, events and exit ignored
    do_reset(); set_cfg(4'b0000);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    check("R9 cause cleared", cause_value, 32'd0);
    set_cfg(4'b1000);
    pulse(1'b1, 1'b0, 1'b1);
    check("R9 no branch", {31'd0, branch_req}, 32'd0);
    check("R9 no capture", cause_value, 32'd0);
    repeat (3) @(negedge clk);
    check("R9 still stopped", {31'd0, chkstop}, 32'd1);
    check("R9 status", {30'd0, status_pins}, 32'd0);

    // R10: debug mode holds, ignores events, leaves on exit strobe
    do_reset(); set_cfg(4'b0110);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    set_cfg(4'b1000);
    pulse(1'b1, 1'b0, 1'b0);
    check("R10 holds debug", {30'd0, status_pins}, 32'd3);
    check("R10 no branch", {31'd0, branch_req}, 32'd0);
    check("R10 no capture", cause_value, 32'd0);
    pulse(1'b0, 1'b0, 1'b1);
    check("R10 exit status", {30'd0, status_pins}, 32'd0);
    check("R10 exit freeze", {31'd0, freeze}, 32'd0);
    check("R10 exit chkstop", {31'd0, chkstop}, 32'd0);
    pulse(1'b1, 1'b0, 1'b0);
    check("R10 running again", {31'd0, branch_req}, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule